// File: doc/BRIEF.md
# Byte-Stream CRC-16 Checker

This block verifies the integrity of a data group that reaches it one byte at a time. Each byte offered on the write strobe is folded into a 16-bit cyclic remainder using the polynomial x^16 + x^12 + x^5 + 1. Because the sender's own check value is part of the group, an undamaged group leaves the remainder at zero. A registered flag reports that condition. Two copies of the flag are provided, one for a pad and one for a status bit.

The group may be of any length and may arrive in many bursts separated by idle cycles. Before each new group, the host raises the clear control for at least one cycle and then lowers it. While clear is high, the remainder is held at zero and any byte offered on the strobe is dropped. The front end that gathers bytes from a serial or parallel bus sits outside this block.

Top module: `crc16_stream_checker`

## Requirements
- R1: A synchronous active-high reset sets the check register to 0x0000 and drives both pass outputs to 1.
- R2: Each byte with `wr_i`=1 and `clr_i`=0 is absorbed in one clock cycle. It is processed most significant bit first against polynomial 0x1021, starting from 0x0000. The nine ASCII bytes "123456789" leave the remainder 0x31C3.
- R3: The pass outputs are 1 exactly when all 16 bits of the check register are zero. They change at the same clock edge that absorbs a byte, so they can be read in the following cycle.
- R4: A group followed by its own 16-bit check value, high byte first, ends with pass = 1. If any byte of the group or the check value is altered, the group ends with pass = 0.
- R5: While `clr_i`=1, the check register is forced to 0x0000. Pass reads 1 in the cycle after clear is sampled high.
- R6: A byte strobed while `clr_i`=1 is discarded and has no effect on any later result.
- R7: A cycle with `wr_i`=0 leaves the register and flags unchanged. A group split into bursts with idle gaps gives the same result as the same group sent back to back.
- R8: Group length is unbounded. No counter limits or wraps the byte sequence; a group of 1000 bytes plus its check value passes.
- R9: `pass_pin_o` and `pass_stat_o` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Group clear; high zeroes the remainder and blocks writes |
| wr_i | input | 1 | Byte strobe |
| data_i | input | 8 | Byte to absorb |
| pass_pin_o | output | 1 | Registered pass flag for a pad (1 = no error) |
| pass_stat_o | output | 1 | Registered pass flag for a status bit (1 = no error) |

## Verification
The standard nine-digit ASCII string, followed by its known check value, is streamed back to back. Pass must stay low on every byte and rise only on the last one; this separates a correct polynomial and bit order from one that reaches zero early or never. The same string with one flipped check bit must fail. A 1000-byte group is sent with periodic idle gaps, preceded by junk bytes strobed during clear. A wrong result there would show that bytes leaked through clear, that gaps disturbed the state, or that length wrapped. A lone zero byte and a reset check cover the all-zero starting point.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam int          BYTE_W   = 8;
  localparam int          REM_W    = 16;
  localparam logic [15:0] POLY_STD = 16'h1021;
  localparam logic [15:0] SEED_STD = 16'h0000;
  localparam int          FLAG_CNT = 2;   // pad copy and status copy
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int             DATA_W = 8,
  parameter int             CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crc_i;

  // One shift per data bit, most significant bit first
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][CRC_W-1] ^ data_i[DATA_W-1-b];
    assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] SEED  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CRC_W-1:0] crc_d,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= SEED;
    else if (load)  crc_q <= crc_d;
  end
endmodule

// File: rtl/crc_pass_flag.sv
module crc_pass_flag #(
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] SEED  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CRC_W-1:0] crc_d,
  output logic             pass_o
);
  localparam logic SEED_PASS = (SEED == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) pass_o <= SEED_PASS;
    else if (load)  pass_o <= (crc_d == '0);
  end
endmodule

// File: rtl/crc16_stream_checker.sv
module crc16_stream_checker
  import crc_chk_pkg::*;
#(
  parameter int                DATA_W = BYTE_W,
  parameter int                CRC_W  = REM_W,
  parameter logic [CRC_W-1:0]  POLY   = POLY_STD,
  parameter logic [CRC_W-1:0]  SEED   = SEED_STD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pass_pin_o,
  output logic              pass_stat_o
);
  logic             absorb;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;
  logic [FLAG_CNT-1:0] flags;

  assign absorb = wr_i & ~clr_i;

  crc_byte_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_i (crc_q),
    .data_i(data_i),
    .crc_o (crc_next)
  );

  crc_state_reg #(.CRC_W(CRC_W), .SEED(SEED)) u_state (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_i),
    .load (absorb),
    .crc_d(crc_next),
    .crc_q(crc_q)
  );

  // Separate flag registers for the pad and the status copy
  for (genvar f = 0; f < FLAG_CNT; f++) begin : g_flag
    crc_pass_flag #(.CRC_W(CRC_W), .SEED(SEED)) u_flag (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_i),
      .load  (absorb),
      .crc_d (crc_next),
      .pass_o(flags[f])
    );
  end

  assign pass_pin_o  = flags[0];
  assign pass_stat_o = flags[FLAG_CNT-1];
endmodule

// File: rtl/crc16_stream_checker_chk.sv
module crc16_stream_checker_chk #(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             wr_i,
  input logic [CRC_W-1:0] crc_q,
  input logic             pass_pin_o,
  input logic             pass_stat_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (crc_q == '0 && pass_pin_o && pass_stat_o));

  assert_flag_matches_zero_R3: assert property (@(posedge clk) disable iff (rst)
    pass_pin_o == (crc_q == '0));

  assert_clear_gives_pass_R5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pass_pin_o && crc_q == '0));

  assert_write_in_clear_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && wr_i) |=> (crc_q == '0));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !clr_i) |=> ($stable(crc_q) && $stable(pass_pin_o)));

  assert_copies_agree_R9: assert property (@(posedge clk) disable iff (rst)
    pass_pin_o == pass_stat_o);
endmodule

bind crc16_stream_checker crc16_stream_checker_chk #(.CRC_W(CRC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_i      (clr_i),
  .wr_i       (wr_i),
  .crc_q      (crc_q),
  .pass_pin_o (pass_pin_o),
  .pass_stat_o(pass_stat_o)
);

// File: tb/crc16_stream_checker_tb.sv
`timescale 1ns/1ps
module crc16_stream_checker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       pass_pin_o, pass_stat_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  crc16_stream_checker u_dut (
    .clk(clk), .rst(rst), .clr_i(clr_i), .wr_i(wr_i), .data_i(data_i),
    .pass_pin_o(pass_pin_o), .pass_stat_o(pass_stat_o)
  );

  // {byte, expected pass after absorbing it}: "123456789" then 0x31C3
  localparam int NV = 11;
  localparam logic [8:0] VEC [NV] = '{
    {8'h31,1'b0},{8'h32,1'b0},{8'h33,1'b0},{8'h34,1'b0},{8'h35,1'b0},
    {8'h36,1'b0},{8'h37,1'b0},{8'h38,1'b0},{8'h39,1'b0},
    {8'h31,1'b0},{8'hC3,1'b1}
  };

  function automatic logic [15:0] model(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (pass_pin_o !== exp || pass_stat_o !== exp) begin
      n_bad++;
      $display("FAIL %s pin=%b stat=%b expected=%b", tag, pass_pin_o, pass_stat_o, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); wr_i = 1'b1; data_i = b;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic clear_group();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  initial begin
    #(4.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] ref_crc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1'b1, "R1 reset state");

    // Table walk, one byte per cycle (R2, R3, R4)
    clear_group();
    wr_i = 1'b1; data_i = VEC[0][8:1];
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(VEC[i][0], $sformatf("R2 R3 vector %0d", i));
      if (i < NV-1) data_i = VEC[i+1][8:1];
      else          wr_i = 1'b0;
    end

    // R7 idle cycles keep the pass
    repeat (5) @(negedge clk);
    check(1'b1, "R7 idle hold");

    // R4 corrupted check byte fails
    clear_group();
    check(1'b1, "R5 pass after clear");
    for (int i = 0; i < 9; i++) send(VEC[i][8:1]);
    send(8'h31); send(8'hC2);
    check(1'b0, "R4 corrupted check value");

    // R6 writes during clear ignored
    @(negedge clk); clr_i = 1'b1; wr_i = 1'b1; data_i = 8'hA5;
    @(negedge clk); data_i = 8'h5A;
    @(negedge clk); clr_i = 1'b0; wr_i = 1'b0;
    check(1'b1, "R6 pass during/after blocked writes");
    send(8'h00);
    check(1'b1, "R3 zero byte keeps zero remainder");

    // R8 long fragmented group, R7 gaps, R6 bytes before were dropped
    ref_crc = 16'h0000;
    for (int i = 0; i < 1000; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + 5) & 8'hFF);
      ref_crc = model(ref_crc, b);
      send(b);
      if (i % 7 == 0) repeat (3) @(negedge clk);
    end
    check(ref_crc == 16'h0000, "R8 long group body");
    send(ref_crc[15:8]);
    repeat (4) @(negedge clk);
    send(ref_crc[7:0]);
    check(1'b1, "R8 R7 long fragmented group passes");

    // R4 altered data byte fails
    clear_group();
    send(8'h31); send(8'h32); send(8'h30);
    for (int i = 3; i < 9; i++) send(VEC[i][8:1]);
    send(8'h31); send(8'hC3);
    check(1'b0, "R4 corrupted data byte");

    // R1 reset mid-group
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(1'b1, "R1 reset mid-group");
    check(pass_stat_o, "R9 copies agree");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule